// File: doc/BRIEF.md
# SPI Register and Pipelined RAM Slave

This block is the host-facing serial port of a line-card device. A host talks to it over SPI (mode 3, MSB first). The host sends a control byte and an address byte. Then it either moves one 8-bit value to or from an internal register file, or moves one 16-bit word to or from an internal RAM. The block decodes each frame and issues requests on two valid/ready request channels: one for the register file and one for the RAM. It shifts read data back on MISO.

RAM traffic is pipelined. A RAM read returns the word that the previous RAM read fetched, so the host must prime the pipe with one extra read. A RAM write is only staged, and it lands in the RAM at the start of the next RAM access. The host may release chip select after every byte or after every pair of bytes, or it may hold chip select across several accesses. In the held case, every access fills a whole number of 16-bit units, so a register access grows to four bytes.

Back-pressure rules:
- Each request channel holds its valid and its payload steady until ready is seen high at a clock edge.
- The RAM returns read data with a single `ram_rvalid` pulse. It may arrive any number of cycles after the accepting edge, and it cannot be stalled.
- A register read takes its data from `reg_rdata` in the accepting cycle.
- A register read must be accepted within half an SCLK period of the end of the address byte.
- RAM requests must be accepted, and their reads answered, within one byte time.

Top module: `spi_regram_slave`

## Requirements
- R1: After reset, `spi_miso` is 0, neither request channel is valid, the pending-read word is 0 and no RAM write is staged.
- R2: Control byte decode. Bit 7 set means read, clear means write. Bit 5 set selects register space, whatever bit 6 holds. Bit 5 clear with bit 6 clear selects RAM space. Bit 5 clear with bit 6 set selects nothing: the frame is consumed as a register-length frame and raises no request.
- R3: A register write is three bytes: control, address, data. One write request carrying that address and data is issued after the data byte.
- R4: A register read issues one read request after the address byte. The returned byte is shifted out on MISO during the third byte, MSB first, changing on falling SCLK and valid at the rising edge.
- R5: With chip select held, a register access takes four bytes. On a read, the fourth byte repeats the data byte. On a write, the data comes from the third byte and the fourth byte has no effect.
- R6: A RAM read (four bytes) returns on MISO, high byte first in bytes three and four, the word fetched by the preceding RAM read. The first RAM read after reset returns 0x0000.
- R7: A RAM write (four bytes, high data byte first) raises no RAM request itself. It is committed at the next RAM access, after that access's address byte, and before that access's own read request.
- R8: A rising chip select clears the bit count. It also ends a register or no-space frame when all three of its bytes have been sent. Otherwise the byte position is kept, so chip select may be released between any two bytes.
- R9: A request that is not accepted keeps its valid, address, direction and write data unchanged in the next cycle.
- R10: At most one RAM read is outstanding, and the register and RAM channels are never valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock, idle high |
| spi_csn | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, 0 while deselected |
| reg_valid | output | 1 | Register request valid |
| reg_ready | input | 1 | Register request accepted |
| reg_we | output | 1 | 1 = register write, 0 = read |
| reg_addr | output | 8 | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data, valid in accepting cycle |
| ram_valid | output | 1 | RAM request valid |
| ram_ready | input | 1 | RAM request accepted |
| ram_we | output | 1 | 1 = RAM write, 0 = read |
| ram_addr | output | 8 | RAM word address |
| ram_wdata | output | 16 | RAM write word |
| ram_rvalid | input | 1 | RAM read data strobe |
| ram_rdata | input | 16 | RAM read word |

## Verification
The SPI inputs pass through a two-stage synchronizer, and a detected edge takes one more register. So a MISO bit settles about four clocks after its falling SCLK edge, and the bench samples it twelve clocks later, just before the next rising edge. Port requests appear a few cycles after the rising edge that ends the address or data byte. A scoreboard monitor compares each one in its accepting cycle, and a request arriving with no expectation queued fails. RAM read data is checked one access late, as R6 requires. Each chip-select release is followed by a settle gap long enough for pending handshakes to drain before the queue is checked.

// File: rtl/spi_regram_pkg.sv
package spi_regram_pkg;
  localparam int BYTE_W        = 8;
  localparam int WORD_W        = 2 * BYTE_W;
  localparam int CTRL_READ_BIT = 7;
  localparam int CTRL_NRAM_BIT = 6;
  localparam int CTRL_REG_BIT  = 5;
  localparam int SLOT_W        = 2;

  typedef enum logic [1:0] {
    SPACE_NONE = 2'd0,
    SPACE_REG  = 2'd1,
    SPACE_RAM  = 2'd2
  } space_e;

  // Register bit wins; RAM needs both space bits clear.
  function automatic space_e decode_space(input logic [BYTE_W-1:0] c);
    if (c[CTRL_REG_BIT])        return SPACE_REG;
    else if (!c[CTRL_NRAM_BIT]) return SPACE_RAM;
    else                        return SPACE_NONE;
  endfunction
endpackage

// File: rtl/spi_regram_link.sv
module spi_regram_link
  import spi_regram_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              csn_i,
  input  logic              mosi_i,
  input  logic              tx_load,
  input  logic [WORD_W-1:0] tx_word,
  output logic              miso_o,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val,
  output logic              cs_rise
);
  localparam int BIT_CNT_W = $clog2(BYTE_W);
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

  logic [SYNC_STAGES-1:0] sclk_sync, csn_sync, mosi_sync;
  logic                   sclk_prev, csn_prev;
  logic                   sclk_s, csn_s, mosi_s;
  logic                   rise, fall;
  logic [BIT_CNT_W-1:0]   bit_cnt;
  logic [BYTE_W-1:0]      rx_sh;
  logic [WORD_W-1:0]      tx_sh;
  logic                   miso_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sync <= '1;
      csn_sync  <= '1;
      mosi_sync <= '0;
    end else begin
      for (int i = SYNC_STAGES - 1; i > 0; i--) begin
        sclk_sync[i] <= sclk_sync[i-1];
        csn_sync[i]  <= csn_sync[i-1];
        mosi_sync[i] <= mosi_sync[i-1];
      end
      sclk_sync[0] <= sclk_i;
      csn_sync[0]  <= csn_i;
      mosi_sync[0] <= mosi_i;
    end
  end

  assign sclk_s = sclk_sync[SYNC_STAGES-1];
  assign csn_s  = csn_sync[SYNC_STAGES-1];
  assign mosi_s = mosi_sync[SYNC_STAGES-1];
  assign rise   = !csn_s && sclk_s && !sclk_prev;
  assign fall   = !csn_s && !sclk_s && sclk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev <= 1'b1;
      csn_prev  <= 1'b1;
      cs_rise   <= 1'b0;
      byte_done <= 1'b0;
      byte_val  <= '0;
      bit_cnt   <= '0;
      rx_sh     <= '0;
    end else begin
      sclk_prev <= sclk_s;
      csn_prev  <= csn_s;
      cs_rise   <= csn_s && !csn_prev;
      byte_done <= 1'b0;
      if (csn_s) begin
        bit_cnt <= '0;
      end else if (rise) begin
        rx_sh <= {rx_sh[BYTE_W-2:0], mosi_s};
        if (bit_cnt == LAST_BIT) begin
          bit_cnt   <= '0;
          byte_done <= 1'b1;
          byte_val  <= {rx_sh[BYTE_W-2:0], mosi_s};
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  // Mode 3 transmit: next bit presented on each falling edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh  <= '0;
      miso_q <= 1'b0;
    end else begin
      if (tx_load)   tx_sh <= tx_word;
      else if (fall) tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
      if (csn_s)     miso_q <= 1'b0;
      else if (fall) miso_q <= tx_sh[WORD_W-1];
    end
  end

  assign miso_o = miso_q;
endmodule

// File: rtl/spi_regram_seq.sv
module spi_regram_seq
  import spi_regram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic              cs_rise,
  output logic              reg_valid,
  input  logic              reg_ready,
  output logic              reg_we,
  output logic [BYTE_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic              tx_load,
  output logic [WORD_W-1:0] tx_word,
  output logic              ram_start,
  output logic              ram_start_rd,
  output logic [BYTE_W-1:0] ram_start_addr,
  output logic              stage_v,
  output logic [BYTE_W-1:0] stage_addr,
  output logic [WORD_W-1:0] stage_data,
  input  logic [WORD_W-1:0] pend_word
);
  localparam logic [SLOT_W-1:0] SLOT_CTRL = 2'd0;
  localparam logic [SLOT_W-1:0] SLOT_ADDR = 2'd1;
  localparam logic [SLOT_W-1:0] SLOT_D0   = 2'd2;
  localparam logic [SLOT_W-1:0] SLOT_D1   = 2'd3;

  logic [SLOT_W-1:0] slot;
  logic [BYTE_W-1:0] ctrl_q, addr_q, hi_q;
  space_e            space_q, space_now;
  logic              rd_q, rd_now;

  assign space_now = decode_space(ctrl_q);
  assign rd_now    = ctrl_q[CTRL_READ_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot           <= SLOT_CTRL;
      ctrl_q         <= '0;
      addr_q         <= '0;
      hi_q           <= '0;
      space_q        <= SPACE_NONE;
      rd_q           <= 1'b0;
      reg_valid      <= 1'b0;
      reg_we         <= 1'b0;
      reg_addr       <= '0;
      reg_wdata      <= '0;
      tx_load        <= 1'b0;
      tx_word        <= '0;
      ram_start      <= 1'b0;
      ram_start_rd   <= 1'b0;
      ram_start_addr <= '0;
      stage_v        <= 1'b0;
      stage_addr     <= '0;
      stage_data     <= '0;
    end else begin
      tx_load   <= 1'b0;
      ram_start <= 1'b0;
      stage_v   <= 1'b0;

      if (reg_valid && reg_ready) begin
        reg_valid <= 1'b0;
        if (!reg_we) begin
          tx_load <= 1'b1;
          tx_word <= {reg_rdata, reg_rdata};  // mirrored into both halves
        end
      end

      // Short register frame ends on deselect after its data byte.
      if (cs_rise && slot == SLOT_D1 && space_q != SPACE_RAM) begin
        slot    <= SLOT_CTRL;
        tx_load <= 1'b1;
        tx_word <= '0;
      end

      if (byte_done) begin
        slot <= slot + 2'd1;
        case (slot)
          SLOT_CTRL: ctrl_q <= byte_val;
          SLOT_ADDR: begin
            addr_q  <= byte_val;
            space_q <= space_now;
            rd_q    <= rd_now;
            tx_load <= 1'b1;
            tx_word <= (space_now == SPACE_RAM && rd_now) ? pend_word : '0;
            if (space_now == SPACE_REG && rd_now) begin
              reg_valid <= 1'b1;
              reg_we    <= 1'b0;
              reg_addr  <= byte_val;
            end
            if (space_now == SPACE_RAM) begin
              ram_start      <= 1'b1;
              ram_start_rd   <= rd_now;
              ram_start_addr <= byte_val;
            end
          end
          SLOT_D0: begin
            hi_q <= byte_val;
            if (space_q == SPACE_REG && !rd_q) begin
              reg_valid <= 1'b1;
              reg_we    <= 1'b1;
              reg_addr  <= addr_q;
              reg_wdata <= byte_val;
            end
          end
          default: begin
            if (space_q == SPACE_RAM && !rd_q) begin
              stage_v    <= 1'b1;
              stage_addr <= addr_q;
              stage_data <= {hi_q, byte_val};
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_regram_rampipe.sv
module spi_regram_rampipe
  import spi_regram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_rd,
  input  logic [BYTE_W-1:0] start_addr,
  input  logic              stage_v,
  input  logic [BYTE_W-1:0] stage_addr,
  input  logic [WORD_W-1:0] stage_data,
  output logic [WORD_W-1:0] pend_word,
  output logic              ram_valid,
  input  logic              ram_ready,
  output logic              ram_we,
  output logic [BYTE_W-1:0] ram_addr,
  output logic [WORD_W-1:0] ram_wdata,
  input  logic              ram_rvalid,
  input  logic [WORD_W-1:0] ram_rdata
);
  typedef enum logic [1:0] {RP_IDLE, RP_WR, RP_RD, RP_WAIT} rp_state_e;

  rp_state_e         state;
  logic              stg_valid, rd_want;
  logic [BYTE_W-1:0] stg_addr, rd_addr;
  logic [WORD_W-1:0] stg_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RP_IDLE;
      stg_valid <= 1'b0;
      stg_addr  <= '0;
      stg_data  <= '0;
      rd_want   <= 1'b0;
      rd_addr   <= '0;
      pend_word <= '0;
    end else begin
      case (state)
        RP_WR: if (ram_ready) begin
          stg_valid <= 1'b0;
          state     <= rd_want ? RP_RD : RP_IDLE;
        end
        RP_RD:   if (ram_ready)  state <= RP_WAIT;
        RP_WAIT: if (ram_rvalid) begin
          pend_word <= ram_rdata;
          state     <= RP_IDLE;
        end
        default: ;
      endcase
      if (start) begin
        rd_want <= start_rd;
        rd_addr <= start_addr;
        // Older staged write goes first, keeping read-after-write order.
        if (stg_valid)     state <= RP_WR;
        else if (start_rd) state <= RP_RD;
      end
      if (stage_v) begin
        stg_valid <= 1'b1;
        stg_addr  <= stage_addr;
        stg_data  <= stage_data;
      end
    end
  end

  assign ram_valid = (state == RP_WR) || (state == RP_RD);
  assign ram_we    = (state == RP_WR);
  assign ram_addr  = (state == RP_WR) ? stg_addr : rd_addr;
  assign ram_wdata = stg_data;
endmodule

// File: rtl/spi_regram_slave.sv
module spi_regram_slave
  import spi_regram_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_csn,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              reg_valid,
  input  logic              reg_ready,
  output logic              reg_we,
  output logic [BYTE_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic              ram_valid,
  input  logic              ram_ready,
  output logic              ram_we,
  output logic [BYTE_W-1:0] ram_addr,
  output logic [WORD_W-1:0] ram_wdata,
  input  logic              ram_rvalid,
  input  logic [WORD_W-1:0] ram_rdata
);
  logic              byte_done, cs_rise, tx_load;
  logic [BYTE_W-1:0] byte_val;
  logic [WORD_W-1:0] tx_word, pend_word;
  logic              ram_start, ram_start_rd, stage_v;
  logic [BYTE_W-1:0] ram_start_addr, stage_addr;
  logic [WORD_W-1:0] stage_data;

  spi_regram_link #(.SYNC_STAGES(SYNC_STAGES)) u_link (
    .clk(clk), .rst_n(rst_n),
    .sclk_i(spi_sclk), .csn_i(spi_csn), .mosi_i(spi_mosi),
    .tx_load(tx_load), .tx_word(tx_word),
    .miso_o(spi_miso), .byte_done(byte_done), .byte_val(byte_val),
    .cs_rise(cs_rise)
  );

  spi_regram_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .byte_done(byte_done), .byte_val(byte_val), .cs_rise(cs_rise),
    .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_load(tx_load), .tx_word(tx_word),
    .ram_start(ram_start), .ram_start_rd(ram_start_rd),
    .ram_start_addr(ram_start_addr),
    .stage_v(stage_v), .stage_addr(stage_addr), .stage_data(stage_data),
    .pend_word(pend_word)
  );

  spi_regram_rampipe u_ram (
    .clk(clk), .rst_n(rst_n),
    .start(ram_start), .start_rd(ram_start_rd), .start_addr(ram_start_addr),
    .stage_v(stage_v), .stage_addr(stage_addr), .stage_data(stage_data),
    .pend_word(pend_word),
    .ram_valid(ram_valid), .ram_ready(ram_ready), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rvalid(ram_rvalid), .ram_rdata(ram_rdata)
  );
endmodule

// File: rtl/spi_regram_slave_chk.sv
module spi_regram_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_valid,
  input logic        reg_ready,
  input logic        reg_we,
  input logic [7:0]  reg_addr,
  input logic [7:0]  reg_wdata,
  input logic        ram_valid,
  input logic        ram_ready,
  input logic        ram_we,
  input logic [7:0]  ram_addr,
  input logic [15:0] ram_wdata,
  input logic        ram_rvalid
);
  logic rd_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                rd_out <= 1'b0;
    else if (ram_valid && ram_ready && !ram_we) rd_out <= 1'b1;
    else if (ram_rvalid)                       rd_out <= 1'b0;
  end

  // R9: stalled register request holds still
  a_r9_reg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && !reg_ready) |=> (reg_valid && $stable(reg_we) &&
                                   $stable(reg_addr) && $stable(reg_wdata)));

  // R9: stalled RAM request holds still
  a_r9_ram_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_valid && !ram_ready) |=> (ram_valid && $stable(ram_we) &&
                                   $stable(ram_addr) && $stable(ram_wdata)));

  // R10: no second read while one is outstanding
  a_r10_one_read: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_valid && !ram_we) |-> !rd_out);

  // R10: channels mutually exclusive
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_valid && ram_valid));
endmodule

bind spi_regram_slave spi_regram_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .ram_valid(ram_valid), .ram_ready(ram_ready), .ram_we(ram_we),
  .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rvalid(ram_rvalid)
);

// File: tb/spi_regram_slave_tb.sv
`timescale 1ns/1ps
module spi_regram_slave_tb;
  localparam int H = 12;              // SCLK half period in clk cycles
  localparam int WATCHDOG = 150000;

  typedef struct packed {
    logic [1:0]  kind;                // 0 reg wr, 1 reg rd, 2 ram wr, 3 ram rd
    logic [7:0]  addr;
    logic [15:0] data;
  } ev_t;

  logic clk = 0, rst_n = 0;
  logic sclk = 1, csn = 1, mosi = 0;
  logic miso;
  logic reg_valid, reg_ready, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic ram_valid, ram_ready, ram_we, ram_rvalid;
  logic [7:0] ram_addr;
  logic [15:0] ram_wdata, ram_rdata;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  ev_t exp_q[$];

  always #2 clk = ~clk;

  spi_regram_slave u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_csn(csn),
    .spi_mosi(mosi), .spi_miso(miso),
    .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ram_valid(ram_valid), .ram_ready(ram_ready), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rvalid(ram_rvalid), .ram_rdata(ram_rdata)
  );

  // ---------------- memory models (one-cycle back-pressure) ----------------
  logic [7:0]  regs [256];
  logic [15:0] mem  [256];
  logic        rv1;
  logic [15:0] rd_hold;

  assign reg_rdata = regs[reg_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      reg_ready <= 1'b0;
      ram_ready <= 1'b0;
      rv1 <= 1'b0;
      ram_rvalid <= 1'b0;
      ram_rdata <= '0;
      rd_hold <= '0;
    end else begin
      reg_ready <= reg_valid && !reg_ready;
      ram_ready <= ram_valid && !ram_ready;
      if (reg_valid && reg_ready && reg_we) regs[reg_addr] <= reg_wdata;
      if (ram_valid && ram_ready && ram_we) mem[ram_addr] <= ram_wdata;
      rv1 <= ram_valid && ram_ready && !ram_we;
      if (ram_valid && ram_ready && !ram_we) rd_hold <= mem[ram_addr];
      ram_rvalid <= rv1;
      ram_rdata <= rd_hold;
    end
  end

  // ---------------- checks ----------------
  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // ---------------- scoreboard monitor ----------------
  bit rd_busy = 0;
  task automatic see_event(input ev_t got, input string tag);
    ev_t e;
    n_chk++;
    if (exp_q.size() == 0) begin
      n_fail++;
      $display("FAIL %s unexpected request: actual %h expected none", tag, got);
    end else begin
      e = exp_q.pop_front();
      if (e.kind[0] == 1'b1) begin e.data = '0; got.data = '0; end
      if (got !== e) begin
        n_fail++;
        $display("FAIL %s request: actual %h expected %h", tag, got, e);
      end
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      if (reg_valid && reg_ready)
        see_event('{kind: reg_we ? 2'd0 : 2'd1, addr: reg_addr, data: {8'h00, reg_wdata}},
                  "R3/R4/R9 reg");
      if (ram_valid && ram_ready) begin
        if (!ram_we) begin
          n_chk++;
          if (rd_busy) begin
            n_fail++;
            $display("FAIL R10 second read: actual 1 expected 0");
          end
          rd_busy = 1;
        end
        see_event('{kind: ram_we ? 2'd2 : 2'd3, addr: ram_addr, data: ram_wdata},
                  "R7/R9 ram");
      end
      if (ram_rvalid) rd_busy = 0;
    end
  end

  // ---------------- SPI driver ----------------
  task automatic cs_on();
    csn = 0;
    repeat (H) @(negedge clk);
  endtask

  task automatic cs_off();
    csn = 1;
    repeat (3 * H) @(negedge clk);
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      sclk = 0;
      mosi = tx[i];
      repeat (H) @(negedge clk);
      rx[i] = miso;
      sclk = 1;
      repeat (H) @(negedge clk);
    end
  endtask

  // mode 0: CS per byte, 1: CS per byte pair, 2: caller holds CS
  task automatic xfer(input logic [7:0] c, a, d2, d3, input int nb, input int mode,
                      output logic [7:0] r2, output logic [7:0] r3);
    logic [7:0] b [4];
    logic [7:0] r [4];
    b = '{c, a, d2, d3};
    r = '{8'h00, 8'h00, 8'h00, 8'h00};
    for (int k = 0; k < nb; k++) begin
      if (mode == 0 || (mode == 1 && (k % 2) == 0)) cs_on();
      spi_byte(b[k], r[k]);
      if (mode == 0 || (mode == 1 && ((k % 2) == 1 || k == nb - 1))) cs_off();
    end
    r2 = r[2];
    r3 = r[3];
  endtask

  // ---------------- reference model ----------------
  logic [7:0]  regm [256];
  logic [15:0] memm [256];
  logic [15:0] pend_exp = 16'h0000;
  bit          stg_v = 0;
  logic [7:0]  stg_a;
  logic [15:0] stg_d;

  task automatic reg_wr(input logic [7:0] flags, input logic [7:0] a, input logic [7:0] d,
                        input int nb, input int mode);
    logic [7:0] r2, r3;
    exp_q.push_back('{kind: 2'd0, addr: a, data: {8'h00, d}});
    regm[a] = d;
    xfer(8'h20 | flags, a, d, ~d, nb, mode, r2, r3);
  endtask

  task automatic reg_rd(input logic [7:0] a, input int nb, input int mode, input string tag);
    logic [7:0] r2, r3;
    exp_q.push_back('{kind: 2'd1, addr: a, data: 16'h0});
    xfer(8'hA0, a, 8'h00, 8'h00, nb, mode, r2, r3);
    check({tag, " data byte"}, {24'h0, r2}, {24'h0, regm[a]});
    if (nb == 4) check("R5 mirrored byte", {24'h0, r3}, {24'h0, regm[a]});
  endtask

  task automatic flush_stage();
    if (stg_v) begin
      exp_q.push_back('{kind: 2'd2, addr: stg_a, data: stg_d});
      memm[stg_a] = stg_d;
      stg_v = 0;
    end
  endtask

  task automatic ram_wr(input logic [7:0] a, input logic [15:0] d, input int mode);
    logic [7:0] r2, r3;
    flush_stage();
    stg_v = 1; stg_a = a; stg_d = d;
    xfer(8'h00, a, d[15:8], d[7:0], 4, mode, r2, r3);
  endtask

  task automatic ram_rd(input logic [7:0] a, input int mode, input string tag);
    logic [7:0] r2, r3;
    logic [15:0] want;
    flush_stage();
    exp_q.push_back('{kind: 2'd3, addr: a, data: 16'h0});
    want = pend_exp;
    pend_exp = memm[a];
    xfer(8'h80, a, 8'h00, 8'h00, 4, mode, r2, r3);
    check(tag, {16'h0, r2, r3}, {16'h0, want});
  endtask

  task automatic queue_empty(input string tag);
    check(tag, exp_q.size(), 0);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [7:0] r2, r3;
    repeat (5) @(negedge clk);
    check("R1 miso after reset", {31'h0, miso}, 0);
    check("R1 reg_valid after reset", {31'h0, reg_valid}, 0);
    check("R1 ram_valid after reset", {31'h0, ram_valid}, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R3 / R8: write with chip select released after every byte
    reg_wr(8'h00, 8'h10, 8'hA5, 3, 0);
    queue_empty("R3 write issued");
    // R4 / R5: read in 16-bit framing, data mirrored
    reg_rd(8'h10, 4, 1, "R4");
    // R5: held-style four-byte write, pad byte ignored
    reg_wr(8'h00, 8'h10, 8'h3C, 4, 1);
    reg_rd(8'h10, 3, 0, "R5 pad ignored");

    // R2: bit6 set, bit5 clear -> no request, state untouched
    xfer(8'h40, 8'h10, 8'h77, 8'h00, 3, 0, r2, r3);
    queue_empty("R2 no-space frame");
    reg_rd(8'h10, 3, 0, "R2 register unchanged");
    // R2: bit5 wins over bit6
    reg_wr(8'h40, 8'h11, 8'h5A, 3, 0);
    reg_rd(8'h11, 3, 0, "R2 bit5 priority");

    // R7: RAM writes are staged
    ram_wr(8'h20, 16'h1234, 1);
    queue_empty("R7 staged write not issued");
    ram_wr(8'h21, 16'hBEEF, 0);
    // R6: first read returns 0, then pipelined data
    ram_rd(8'h20, 1, "R6 primed read");
    ram_rd(8'h21, 0, "R6 previous word");
    ram_rd(8'h21, 1, "R6 repeat read");

    // R5 / R8: chip select held across several accesses
    cs_on();
    reg_wr(8'h00, 8'h12, 8'h81, 4, 2);
    reg_rd(8'h12, 4, 2, "R5 held read");
    ram_rd(8'h20, 2, "R6 held RAM read");
    cs_off();
    // R8: deselect after the third byte ends the frame
    cs_on();
    reg_rd(8'h12, 3, 2, "R8 short held read");
    cs_off();
    reg_rd(8'h11, 3, 0, "R8 position reset");

    // R7: write then read same word, commit precedes read
    ram_wr(8'h30, 16'hC0DE, 1);
    ram_rd(8'h30, 1, "R7 read after write");
    ram_rd(8'h30, 1, "R7 committed word");
    repeat (20) @(negedge clk);
    queue_empty("R7 R10 scoreboard drained");
    check("R1 miso idle", {31'h0, miso}, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule